// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Ordered Recency

The block is the lookup and replacement core of a small data cache. A 32-bit byte address is cut into a tag, a set index and a byte offset. Each of the 256 sets holds two ways. Every way keeps a valid flag, a dirty flag, a stored tag and a 32-byte line. A request is taken when `req_ready` is high. In the next cycle the block shows whether the access hit. A read hit returns the addressed 32-bit word. A write hit merges the enabled bytes of that word into the line and marks the line dirty.

On a miss the block names a victim way and exposes its tag, line and dirty state, so the requester can write the victim back. It then waits for the requester to return the missing line on the fill port. That line is installed into the victim way. For a write miss, the pending write bytes are merged in first. Each set keeps an MRU/LRU order of its two ways. A hit makes the touched way MRU. A fill is placed at MRU or LRU according to `fill_at_lru`. Placing streaming fills at LRU keeps reused lines in the cache.

The control is a three-state machine:
- IDLE: ready for a request.
- LOOKUP: the result cycle.
- FILL: waiting for the line.

The transitions are:
- IDLE→LOOKUP on an accepted request.
- LOOKUP→IDLE on a hit.
- LOOKUP→FILL on a miss.
- FILL→FILL while no line arrives.
- FILL→IDLE when `fill_valid` is sampled high.

Top module: `cache2w_lru`

## Requirements
- R1: The address fields are tag = addr[31:13], set index = addr[12:5] and offset = addr[4:0]. Offset bits [4:2] pick the 32-bit word within the line (word k occupies line bits [32k+31:32k]). Offset bits [1:0] are ignored. The offset never affects hit, miss or victim choice.
- R2: A synchronous reset clears every valid flag and returns the machine to IDLE, where `req_ready`=1, `resp_valid`=0 and `fill_req`=0. After reset, every access misses.
- R3: A request accepted at a clock edge produces `resp_valid`=1 for exactly the following cycle. `resp_hit` is 1 only if a valid way of the indexed set holds the address tag. `req_ready`, `resp_valid` and `fill_req` are never high together.
- R4: A read hit returns the addressed word of the matching line on `resp_rdata`. On a miss, `resp_rdata` is zero.
- R5: A write hit changes only the bytes of the addressed word whose `req_wstrb` bit is set (bit b covers data bits [8b+7:8b]) and sets the line's dirty flag. It does not start a fill.
- R6: After a miss, `fill_req` is high from the next cycle and stays high until `fill_valid` is sampled. The machine then returns to IDLE.
- R7: The victim is the lowest-numbered invalid way if there is one; otherwise it is the LRU way. `victim_valid` and `victim_tag` report the state of the victim during the miss cycle.
- R8: Every hit makes the accessed way MRU in its set.
- R9: With `fill_at_lru`=0 a filled line becomes MRU. With `fill_at_lru`=1 it becomes LRU, so the next miss in that set evicts it.
- R10: A block is never held in both ways of a set. An access matching a stored valid tag always hits and never allocates.
- R11: A write miss installs the fill line with the pending write bytes merged in and the dirty flag set. A read miss installs the line clean.
- R12: On a miss, `victim_dirty` is 1 exactly when the victim is valid and dirty, and `victim_line` carries its data. On a hit, `victim_valid` and `victim_dirty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write word |
| req_wstrb | input | 4 | Byte enables of the write word |
| fill_at_lru | input | 1 | Fill placement: 0 = MRU, 1 = LRU (sampled with fill) |
| resp_valid | output | 1 | Lookup result cycle |
| resp_hit | output | 1 | Hit indicator |
| resp_rdata | output | 32 | Read word on hit |
| victim_valid | output | 1 | Victim way holds a valid line |
| victim_dirty | output | 1 | Victim needs write-back |
| victim_tag | output | 19 | Victim stored tag |
| victim_line | output | 256 | Victim line data |
| fill_req | output | 1 | Waiting for the missing line |
| fill_valid | input | 1 | Fill line present |
| fill_line | input | 256 | Missing line data |

## Verification
The bound checker watches the handshake every cycle:
- Every accepted request yields one result cycle.
- A miss always leads into a held fill request.
- A hit returns straight to idle.
- Hits never report a victim.
- The indexed set never shows the same valid tag in both ways.

Replacement order, the MRU versus LRU placement of fills, byte-masked merging, dirty write-back reporting and the behaviour after reset depend on access history. Only the bench's scenarios can show these, with its behavioural model compared on every clock.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    // Control phases of the cache
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } cstate_t;

    // Associativity is fixed: one recency bit orders the pair
    localparam int NWAYS = 2;

endpackage

// File: rtl/cache2w_tagway.sv
module cache2w_tagway #(
    parameter int TAG_W = 19,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             ins_en,
    input  logic [IDX_W-1:0] ins_idx,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic             ins_dirty,
    input  logic             mark_en,
    input  logic [IDX_W-1:0] mark_idx
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (ins_en) begin
            valid_q[ins_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            dirty_q[ins_idx] <= ins_dirty;
        end else if (mark_en) begin
            dirty_q[mark_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[ins_idx] <= ins_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/cache2w_dataway.sv
module cache2w_dataway #(
    parameter int LINE_W = 256,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << IDX_W;

    logic [LINE_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/cache2w_recency.sv
module cache2w_recency #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             lru_way,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_mru_way
);
    localparam int SETS = 1 << IDX_W;

    // One bit per set: the way number currently in the LRU position
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (upd_en) begin
            lru_q[upd_idx] <= ~upd_mru_way;
        end
    end

    assign lru_way = lru_q[rd_idx];

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 5,
    parameter int WORD_W = 32,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = (1 << OFF_W) * 8,
    localparam int NBYTES = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [NBYTES-1:0] req_wstrb,
    input  logic              fill_at_lru,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              victim_valid,
    output logic              victim_dirty,
    output logic [TAG_W-1:0]  victim_tag,
    output logic [LINE_W-1:0] victim_line,
    output logic              fill_req,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line
);
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSEL_W = OFF_W - WSEL_W;

    // ---------------- request capture ----------------
    cstate_t           state, state_nx;
    logic              accept;
    logic [ADDR_W-1:0] q_addr;
    logic              q_write;
    logic [WORD_W-1:0] q_wdata;
    logic [NBYTES-1:0] q_wstrb;
    logic              q_vway;

    logic [TAG_W-1:0]  q_tag;
    logic [IDX_W-1:0]  q_idx;
    logic [WSEL_W-1:0] q_wsel;

    assign accept = req_valid && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (accept) begin
            q_addr  <= req_addr;
            q_write <= req_write;
            q_wdata <= req_wdata;
            q_wstrb <= req_wstrb;
        end
    end

    assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
    assign q_idx  = q_addr[OFF_W +: IDX_W];
    assign q_wsel = q_addr[BSEL_W +: WSEL_W];

    // ---------------- storage ----------------
    logic [NWAYS-1:0]             w_valid;
    logic [NWAYS-1:0]             w_dirty;
    logic [NWAYS-1:0][TAG_W-1:0]  w_tag;
    logic [NWAYS-1:0][LINE_W-1:0] w_line;
    logic [NWAYS-1:0]             w_match;
    logic [NWAYS-1:0]             ins_en_w;
    logic [NWAYS-1:0]             mark_en_w;
    logic [NWAYS-1:0]             data_en_w;

    logic              hit;
    logic              hit_way;
    logic              v_way;
    logic              lru_way;
    logic              hit_wr;
    logic              fill_fire;
    logic [LINE_W-1:0] hit_line;
    logic [LINE_W-1:0] merge_src;
    logic [LINE_W-1:0] merged;
    logic [LINE_W-1:0] wr_line;

    assign hit_wr    = (state == ST_LOOKUP) && hit && q_write;
    assign fill_fire = (state == ST_FILL) && fill_valid;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign ins_en_w[w]  = fill_fire && (q_vway == 1'(w));
        assign mark_en_w[w] = hit_wr && (hit_way == 1'(w));
        assign data_en_w[w] = ins_en_w[w] || mark_en_w[w];
        assign w_match[w]   = w_valid[w] && (w_tag[w] == q_tag);

        cache2w_tagway #(
            .TAG_W (TAG_W),
            .IDX_W (IDX_W)
        ) u_tag (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (q_idx),
            .rd_valid (w_valid[w]),
            .rd_dirty (w_dirty[w]),
            .rd_tag   (w_tag[w]),
            .ins_en   (ins_en_w[w]),
            .ins_idx  (q_idx),
            .ins_tag  (q_tag),
            .ins_dirty(q_write),
            .mark_en  (mark_en_w[w]),
            .mark_idx (q_idx)
        );

        cache2w_dataway #(
            .LINE_W (LINE_W),
            .IDX_W  (IDX_W)
        ) u_data (
            .clk     (clk),
            .rd_idx  (q_idx),
            .rd_line (w_line[w]),
            .wr_en   (data_en_w[w]),
            .wr_idx  (q_idx),
            .wr_line (wr_line)
        );
    end

    // ---------------- recency ----------------
    logic recency_en;
    logic recency_mru;

    assign recency_en  = ((state == ST_LOOKUP) && hit) || fill_fire;
    assign recency_mru = fill_fire ? (fill_at_lru ? ~q_vway : q_vway) : hit_way;

    cache2w_recency #(
        .IDX_W (IDX_W)
    ) u_recency (
        .clk         (clk),
        .rst         (rst),
        .rd_idx      (q_idx),
        .lru_way     (lru_way),
        .upd_en      (recency_en),
        .upd_idx     (q_idx),
        .upd_mru_way (recency_mru)
    );

    // ---------------- hit and victim choice ----------------
    assign hit     = |w_match;
    assign hit_way = w_match[1];

    always_comb begin
        if (!w_valid[0]) begin
            v_way = 1'b0;
        end else if (!w_valid[1]) begin
            v_way = 1'b1;
        end else begin
            v_way = lru_way;
        end
    end

    always_ff @(posedge clk) begin
        if ((state == ST_LOOKUP) && !hit) begin
            q_vway <= v_way;
        end
    end

    assign hit_line  = hit_way ? w_line[1] : w_line[0];
    assign merge_src = (state == ST_FILL) ? fill_line : hit_line;

    // Byte-enabled merge of the pending write word into a line
    always_comb begin
        merged = merge_src;
        for (int b = 0; b < NBYTES; b++) begin
            if (q_write && q_wstrb[b]) begin
                merged[int'(q_wsel) * WORD_W + b * 8 +: 8] = q_wdata[b * 8 +: 8];
            end
        end
    end

    assign wr_line = merged;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid)  state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = hit ? ST_IDLE : ST_FILL;
            ST_FILL:   if (fill_valid) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready    = 1'b0;
        resp_valid   = 1'b0;
        resp_hit     = 1'b0;
        resp_rdata   = '0;
        victim_valid = 1'b0;
        victim_dirty = 1'b0;
        victim_tag   = '0;
        victim_line  = '0;
        fill_req     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_LOOKUP: begin
                resp_valid = 1'b1;
                resp_hit   = hit;
                if (hit) begin
                    resp_rdata = hit_line[int'(q_wsel) * WORD_W +: WORD_W];
                end else begin
                    victim_valid = w_valid[v_way];
                    victim_dirty = w_valid[v_way] && w_dirty[v_way];
                    victim_tag   = w_tag[v_way];
                    victim_line  = w_line[v_way];
                end
            end
            ST_FILL: begin
                fill_req = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
    parameter int TAG_W = 19
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  resp_valid,
    input logic                  resp_hit,
    input logic                  victim_valid,
    input logic                  victim_dirty,
    input logic                  fill_req,
    input logic                  fill_valid,
    input logic [1:0]            way_valid,
    input logic [1:0][TAG_W-1:0] way_tag
);

    // R3
    accept_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    // R3
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, resp_valid, fill_req}));

    // R6
    miss_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |=> fill_req);

    // R6
    fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_valid) |=> fill_req);

    // R6
    fill_done_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_valid) |=> req_ready);

    // R5
    hit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |=> req_ready);

    // R10
    no_dup_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !((way_valid == 2'b11) && (way_tag[0] == way_tag[1])));

    // R12
    hit_no_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> (!victim_valid && !victim_dirty));

    // R12
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        victim_dirty |-> victim_valid);

endmodule

bind cache2w_lru cache2w_chk #(
    .TAG_W (TAG_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .victim_valid (victim_valid),
    .victim_dirty (victim_dirty),
    .fill_req     (fill_req),
    .fill_valid   (fill_valid),
    .way_valid    (w_valid),
    .way_tag      (w_tag)
);

// File: tb/cache2w_lru_tb.sv
`timescale 1ns/1ps
module cache2w_lru_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_ready, req_write;
    logic [31:0]  req_addr, req_wdata;
    logic [3:0]   req_wstrb;
    logic         fill_at_lru;
    logic         resp_valid, resp_hit;
    logic [31:0]  resp_rdata;
    logic         victim_valid, victim_dirty;
    logic [18:0]  victim_tag;
    logic [255:0] victim_line;
    logic         fill_req, fill_valid;
    logic [255:0] fill_line;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cache2w_lru u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .fill_at_lru(fill_at_lru), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_rdata(resp_rdata), .victim_valid(victim_valid),
        .victim_dirty(victim_dirty), .victim_tag(victim_tag), .victim_line(victim_line),
        .fill_req(fill_req), .fill_valid(fill_valid), .fill_line(fill_line)
    );

    task automatic check(input bit ok, input string what, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit           m_valid [256][2];
    bit           m_dirty [256][2];
    logic [18:0]  m_tag   [256][2];
    logic [255:0] m_data  [256][2];
    int           m_order [256][2];   // [0] = MRU way, [1] = LRU way
    int           m_phase = 0;        // 0 idle, 1 result, 2 waiting line
    logic [31:0]  m_addr, m_wd;
    logic [3:0]   m_ws;
    bit           m_wr, e_hit;
    int           e_way, e_vway;

    function automatic logic [255:0] apply_word(input logic [255:0] ln, input logic [31:0] a,
                                                input logic [31:0] d, input logic [3:0] s);
        logic [255:0] r = ln;
        for (int b = 0; b < 4; b++)
            if (s[b]) r[a[4:2] * 32 + b * 8 +: 8] = d[b * 8 +: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0;
            for (int s = 0; s < 256; s++) begin
                m_valid[s][0] = 0; m_valid[s][1] = 0;
                m_order[s][0] = 1; m_order[s][1] = 0;
            end
        end else begin
            int s;
            s = int'(m_addr[12:5]);
            case (m_phase)
                0: if (req_valid) begin
                    m_addr = req_addr; m_wr = req_write; m_wd = req_wdata; m_ws = req_wstrb;
                    s = int'(m_addr[12:5]);
                    e_hit = 0; e_way = 0;
                    for (int w = 0; w < 2; w++)
                        if (m_valid[s][w] && m_tag[s][w] == m_addr[31:13]) begin
                            e_hit = 1; e_way = w;
                        end
                    e_vway = -1;
                    for (int w = 1; w >= 0; w--) if (!m_valid[s][w]) e_vway = w;
                    if (e_vway < 0) e_vway = m_order[s][1];
                    m_phase = 1;
                end
                1: begin
                    if (e_hit) begin
                        if (m_wr) begin
                            m_data[s][e_way]  = apply_word(m_data[s][e_way], m_addr, m_wd, m_ws);
                            m_dirty[s][e_way] = 1;
                        end
                        m_order[s][0] = e_way; m_order[s][1] = 1 - e_way;
                        m_phase = 0;
                    end else m_phase = 2;
                end
                default: if (fill_valid) begin
                    m_data[s][e_vway]  = m_wr ? apply_word(fill_line, m_addr, m_wd, m_ws) : fill_line;
                    m_dirty[s][e_vway] = m_wr;
                    m_valid[s][e_vway] = 1;
                    m_tag[s][e_vway]   = m_addr[31:13];
                    if (fill_at_lru) begin
                        m_order[s][1] = e_vway; m_order[s][0] = 1 - e_vway;
                    end else begin
                        m_order[s][0] = e_vway; m_order[s][1] = 1 - e_vway;
                    end
                    m_phase = 0;
                end
            endcase
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int s;
            s = int'(m_addr[12:5]);
            check(req_ready == (m_phase == 0), "R3 req_ready", 256'(req_ready), 256'(m_phase == 0));
            check(resp_valid == (m_phase == 1), "R3 resp_valid", 256'(resp_valid), 256'(m_phase == 1));
            check(fill_req == (m_phase == 2), "R6 fill_req", 256'(fill_req), 256'(m_phase == 2));
            if (m_phase == 1) begin
                check(resp_hit == e_hit, "R3 resp_hit", 256'(resp_hit), 256'(e_hit));
                if (e_hit)
                    check(resp_rdata == m_data[s][e_way][m_addr[4:2] * 32 +: 32], "R4 resp_rdata",
                          256'(resp_rdata), 256'(m_data[s][e_way][m_addr[4:2] * 32 +: 32]));
                else begin
                    check(victim_valid == m_valid[s][e_vway], "R7 victim_valid",
                          256'(victim_valid), 256'(m_valid[s][e_vway]));
                    check(victim_dirty == (m_valid[s][e_vway] && m_dirty[s][e_vway]),
                          "R12 victim_dirty", 256'(victim_dirty),
                          256'(m_valid[s][e_vway] && m_dirty[s][e_vway]));
                    if (m_valid[s][e_vway]) begin
                        check(victim_tag == m_tag[s][e_vway], "R7 victim_tag",
                              256'(victim_tag), 256'(m_tag[s][e_vway]));
                        check(victim_line == m_data[s][e_vway], "R12 victim_line",
                              victim_line, m_data[s][e_vway]);
                    end
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    logic        o_hit, o_vvalid, o_vdirty, o_filled;
    logic [31:0] o_rdata;
    logic [18:0] o_vtag;

    function automatic logic [255:0] mkline(input int seed);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k * 32 +: 32] = {8'(seed), 8'(k), 16'hC0DE};
        return r;
    endfunction

    function automatic logic [31:0] mkaddr(input logic [18:0] t, input logic [7:0] i,
                                           input logic [4:0] o);
        return {t, i, o};
    endfunction

    task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                          input logic [3:0] ws, input logic [255:0] ln, input bit at_lru);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_wdata = wd; req_wstrb = ws;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        o_hit = resp_hit; o_rdata = resp_rdata; o_vvalid = victim_valid;
        o_vdirty = victim_dirty; o_vtag = victim_tag;
        @(posedge clk);
        @(negedge clk);
        o_filled = fill_req;
        if (fill_req) begin
            fill_valid = 1; fill_line = ln; fill_at_lru = at_lru;
            @(posedge clk);
            @(negedge clk);
            fill_valid = 0;
        end
    endtask

    localparam logic [18:0] TA = 19'h40000, TB = 19'h00123, TC = 19'h7ABCD,
                            TD = 19'h00001, TE = 19'h2468A, TF = 19'h13579, TG = 19'h0F0F0;

    initial begin
        rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_wstrb = 0;
        fill_at_lru = 0; fill_valid = 0; fill_line = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R2 reset state
        check(req_ready && !resp_valid && !fill_req, "R2 idle after reset",
              256'({req_ready, resp_valid, fill_req}), 256'(3'b100));

        access(mkaddr(TA, 8'd3, 5'd8), 0, 0, 0, mkline(1), 0);
        check(!o_hit && o_filled, "R2 cold miss", 256'(o_hit), 256'(0));
        check(o_rdata == 0, "R4 rdata zero on miss", 256'(o_rdata), 256'(0));

        access(mkaddr(TA, 8'd3, 5'd8), 0, 0, 0, '0, 0);
        check(o_hit && o_rdata == 32'h0102C0DE, "R4 read hit word2", 256'(o_rdata), 256'h0102C0DE);
        access(mkaddr(TA, 8'd3, 5'd11), 0, 0, 0, '0, 0);
        check(o_rdata == 32'h0102C0DE, "R1 low offset bits ignored", 256'(o_rdata), 256'h0102C0DE);

        access(mkaddr(TB, 8'd3, 5'd0), 0, 0, 0, mkline(2), 0);
        check(!o_vvalid, "R7 invalid way chosen first", 256'(o_vvalid), 256'(0));

        access(mkaddr(TA, 8'd3, 5'd4), 1, 32'hAABBCCDD, 4'b0101, '0, 0);
        check(o_hit && !o_filled, "R5 write hit no fill", 256'(o_filled), 256'(0));
        access(mkaddr(TA, 8'd3, 5'd4), 0, 0, 0, '0, 0);
        check(o_rdata == 32'h01BBC0DD, "R5 masked write", 256'(o_rdata), 256'h01BBC0DD);

        access(mkaddr(TB, 8'd3, 5'd0), 0, 0, 0, '0, 0);   // B becomes MRU
        access(mkaddr(TC, 8'd3, 5'd0), 0, 0, 0, mkline(3), 1);
        check(o_vtag == TA, "R8 LRU after hit on other way", 256'(o_vtag), 256'(TA));
        check(o_vdirty, "R12 dirty victim reported", 256'(o_vdirty), 256'(1));

        access(mkaddr(TD, 8'd3, 5'd0), 0, 0, 0, mkline(4), 0);
        check(o_vtag == TC && !o_vdirty, "R9 LRU-inserted line evicted first", 256'(o_vtag), 256'(TC));
        access(mkaddr(TB, 8'd3, 5'd0), 0, 0, 0, '0, 0);
        check(o_hit, "R9 reused line kept", 256'(o_hit), 256'(1));
        access(mkaddr(TD, 8'd3, 5'd0), 0, 0, 0, '0, 0);
        check(o_hit && !o_filled, "R10 matching access never allocates", 256'(o_filled), 256'(0));

        access(mkaddr(TA, 8'd4, 5'd0), 0, 0, 0, mkline(6), 0);
        check(!o_hit && !o_vvalid, "R1 other set independent", 256'(o_hit), 256'(0));

        access(mkaddr(TE, 8'd5, 5'd28), 1, 32'h12345678, 4'b1111, mkline(5), 0);
        access(mkaddr(TE, 8'd5, 5'd28), 0, 0, 0, '0, 0);
        check(o_rdata == 32'h12345678, "R11 write miss merged", 256'(o_rdata), 256'h12345678);
        access(mkaddr(TE, 8'd5, 5'd24), 0, 0, 0, '0, 0);
        check(o_rdata == 32'h0506C0DE, "R11 untouched word", 256'(o_rdata), 256'h0506C0DE);
        access(mkaddr(TF, 8'd5, 5'd0), 0, 0, 0, mkline(7), 0);
        access(mkaddr(TG, 8'd5, 5'd0), 0, 0, 0, mkline(8), 0);
        check(o_vtag == TE && o_vdirty, "R11 write-miss line dirty", 256'(o_vdirty), 256'(1));

        // Streaming over one set with alternating placement
        for (int n = 0; n < 40; n++)
            access(mkaddr(19'(n * 7 + 100), 8'd7, 5'(n)), n[0], 32'(n * 3), 4'(n), mkline(n + 20), n[1]);
        for (int n = 0; n < 40; n++)
            access(mkaddr(19'(n % 5 + 100), 8'd7, 5'(n)), 0, 0, 0, mkline(n + 60), 0);

        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        access(mkaddr(TB, 8'd3, 5'd0), 0, 0, 0, mkline(9), 0);
        check(!o_hit, "R2 reset invalidates", 256'(o_hit), 256'(0));

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule